// File: doc/BRIEF.md
# LSB-Justified Audio Serial Transmitter

This block is a master-mode serializer for stereo audio in the LSB-justified format. Samples are written through a 16-bit data port into a one-sample holding register. The block divides the system clock down to a serial bit clock and drives a word-select line that marks the left and right channel slots. It shifts each slot out on a serial data line. Every channel slot is a fixed number of bits long (32 by default). The sample sits at the end of the slot, so its last bit is the last bit of the slot, and the unused leading bits are sent as zeros.

Two sample sizes are supported, chosen by a format input. A 16-bit sample needs one write. A 24-bit sample needs two writes: the first carries the upper byte and the second carries the lower 16 bits. A polarity input sets the idle level of the serial clock. The framing is the same for either level. When a slot begins and no complete sample is waiting, the slot is filled with zeros and an underrun flag is raised for that slot.

The format and polarity inputs are meant to be set while reset is asserted and held afterwards. The first slot, which is a left slot, starts on the first transition of the serial clock back to its idle level after reset.

Top module: `lsbj_audio_tx`

## Requirements
- R1: Slots are 32 serial clock periods long and alternate left then right, starting with left after reset; `ws` is 0 during a left slot and 1 during a right slot.
- R2: With `cfg_fmt`=0 (16-bit), a slot carries 16 zero bits followed by the 16 written bits, most significant bit first.
- R3: With `cfg_fmt`=1 (24-bit), a slot carries 8 zero bits followed by D[23:0], most significant bit first; the first write supplies D[23:16] in `wr_data[7:0]` (`wr_data[15:8]` has no effect) and the second write supplies D[15:0].
- R4: The serial clock period is 2*DIV_HALF system clock cycles, and `sck` rests at the level of `cfg_cpol` whenever it is idle.
- R5: `sd` and `ws` change only in the system clock cycle in which `sck` returns to the level of `cfg_cpol`; the receiver samples on the opposite `sck` edge.
- R6: `tx_empty` is 1 while the holding register can take a write; a write made while `tx_empty` is 0 is ignored and does not alter the sample waiting.
- R7: If a slot starts with no complete sample waiting, the slot is all zeros and `underrun` is 1 for that slot; `underrun` is 0 during a slot that starts with a sample.
- R8: In 24-bit mode, a slot that starts after only the first write of a pair is an underrun slot; the first half is kept, and the next write completes the sample for a later slot.
- R9: During reset `sck` equals `cfg_cpol`, `ws`=1, `sd`=0, `tx_empty`=1 and `underrun`=0.
- R10: The sample waiting is moved into the shifter in the cycle its slot starts, so `tx_empty` is 1 from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fmt | input | 1 | Sample size: 0 = 16-bit, 1 = 24-bit (two writes) |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 16 | Write data |
| tx_empty | output | 1 | Holding register can accept a write |
| underrun | output | 1 | Current slot started without a complete sample |
| sck | output | 1 | Serial bit clock |
| ws | output | 1 | Word select: 0 = left slot, 1 = right slot |
| sd | output | 1 | Serial data, MSB first |

## Verification
A write is captured on the next system clock edge, and `tx_empty` drops in that same cycle once a sample is complete. A slot begins on the edge where `sck` returns to idle. On that edge `ws`, the first bit, `underrun` and the rising `tx_empty` all appear together, and each following bit is launched 2*DIV_HALF cycles after the previous one. The first slot begins 2*DIV_HALF cycles after reset is released. The bench monitor samples every output on the falling system clock edge that follows the `sck` edge leaving idle, which is DIV_HALF cycles after launch. This matches what an external receiver would see. The driver issues each write just after it observes a slot start, so every sample is complete a full slot before the slot that must carry it.

// File: rtl/lsbj_pkg.sv
`timescale 1ns/1ps
package lsbj_pkg;
   parameter int unsigned SLOT_BITS_DEF = 32;
   parameter int unsigned WORD_W        = 16;
   parameter int unsigned SAMPLE_W      = 24;
   localparam int unsigned HI_W         = SAMPLE_W - WORD_W;

   typedef enum logic {
      FMT_16 = 1'b0,
      FMT_24 = 1'b1
   } fmt_e;
endpackage

// File: rtl/lsbj_sck_gen.sv
`timescale 1ns/1ps
module lsbj_sck_gen #(
   parameter int unsigned DIV_HALF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cpol,
   output logic sck,
   output logic launch
);
   logic ph_q;
   logic tick;

   generate
      if (DIV_HALF < 1) begin : g_bad_div
         $error("lsbj_sck_gen: DIV_HALF must be at least 1");
      end
      if (DIV_HALF <= 1) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         localparam int unsigned CW = $clog2(DIV_HALF);
         localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt_q <= '0;
            else if (cnt_q == LAST)  cnt_q <= '0;
            else                     cnt_q <= cnt_q + 1'b1;
         end
         assign tick = (cnt_q == LAST);
      end
   endgenerate

   // ph_q = 1 means sck is away from its idle level
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ph_q <= 1'b0;
      else if (tick) ph_q <= ~ph_q;
   end

   assign launch = tick & ph_q;
   assign sck    = ph_q ^ cpol;
endmodule

// File: rtl/lsbj_stage.sv
`timescale 1ns/1ps
module lsbj_stage
   import lsbj_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  fmt_e                fmt,
   input  logic                wr_en,
   input  logic [WORD_W-1:0]   wr_data,
   input  logic                take,
   output logic                full,
   output logic [SAMPLE_W-1:0] sample
);
   logic [HI_W-1:0]     hi_q;
   logic                hi_ok_q;
   logic                full_q;
   logic [SAMPLE_W-1:0] smp_q;
   logic                accept;
   logic                done;

   assign accept = wr_en & ~full_q;
   assign done   = accept & ((fmt == FMT_16) | hi_ok_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q    <= '0;
         hi_ok_q <= 1'b0;
         full_q  <= 1'b0;
         smp_q   <= '0;
      end else begin
         if (accept && fmt == FMT_24 && !hi_ok_q) begin
            hi_q    <= wr_data[HI_W-1:0];
            hi_ok_q <= 1'b1;
         end
         if (done) begin
            smp_q   <= (fmt == FMT_24) ? {hi_q, wr_data} : {{HI_W{1'b0}}, wr_data};
            hi_ok_q <= 1'b0;
         end
         full_q <= (full_q & ~take) | done;
      end
   end

   assign full   = full_q;
   assign sample = smp_q;
endmodule

// File: rtl/lsbj_slot_shift.sv
`timescale 1ns/1ps
module lsbj_slot_shift
   import lsbj_pkg::*;
#(
   parameter int unsigned SLOT_BITS = SLOT_BITS_DEF
) (
   input  logic                clk,
   input  logic                rst_n,
   input  fmt_e                fmt,
   input  logic                launch,
   input  logic                stage_full,
   input  logic [SAMPLE_W-1:0] stage_sample,
   output logic                take,
   output logic                sd,
   output logic                ws,
   output logic                underrun
);
   localparam int unsigned CW = $clog2(SLOT_BITS);
   localparam logic [CW-1:0] LAST_BIT = CW'(SLOT_BITS - 1);

   generate
      if (SLOT_BITS <= SAMPLE_W) begin : g_bad_slot
         $error("lsbj_slot_shift: SLOT_BITS must exceed the widest sample");
      end
   endgenerate

   logic [CW-1:0]        bit_q;
   logic                 started_q;
   logic [SLOT_BITS-1:0] sh_q;
   logic                 ws_q;
   logic                 urun_q;
   logic                 slot_start;
   logic [SLOT_BITS-1:0] slot_word;

   assign slot_start = launch & (~started_q | (bit_q == LAST_BIT));
   assign take       = slot_start & stage_full;

   // Right-justify the sample in the slot, zero padding in front
   always_comb begin
      if (fmt == FMT_24)
         slot_word = {{(SLOT_BITS-SAMPLE_W){1'b0}}, stage_sample};
      else
         slot_word = {{(SLOT_BITS-WORD_W){1'b0}}, stage_sample[WORD_W-1:0]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_q     <= '0;
         started_q <= 1'b0;
         sh_q      <= '0;
         ws_q      <= 1'b1;
         urun_q    <= 1'b0;
      end else if (slot_start) begin
         bit_q     <= '0;
         started_q <= 1'b1;
         ws_q      <= ~ws_q;
         sh_q      <= stage_full ? slot_word : '0;
         urun_q    <= ~stage_full;
      end else if (launch && started_q) begin
         bit_q     <= bit_q + 1'b1;
         sh_q      <= {sh_q[SLOT_BITS-2:0], 1'b0};
      end
   end

   assign sd       = sh_q[SLOT_BITS-1];
   assign ws       = ws_q;
   assign underrun = urun_q;
endmodule

// File: rtl/lsbj_audio_tx.sv
`timescale 1ns/1ps
module lsbj_audio_tx
   import lsbj_pkg::*;
#(
   parameter int unsigned DIV_HALF  = 4,
   parameter int unsigned SLOT_BITS = SLOT_BITS_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_fmt,
   input  logic              cfg_cpol,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   output logic              tx_empty,
   output logic              underrun,
   output logic              sck,
   output logic              ws,
   output logic              sd
);
   fmt_e                fmt;
   logic                launch;
   logic                take;
   logic                stage_full;
   logic [SAMPLE_W-1:0] stage_sample;

   assign fmt = fmt_e'(cfg_fmt);

   lsbj_sck_gen #(.DIV_HALF(DIV_HALF)) i_sck_gen (
      .clk    (clk),
      .rst_n  (rst_n),
      .cpol   (cfg_cpol),
      .sck    (sck),
      .launch (launch)
   );

   lsbj_stage i_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .fmt     (fmt),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .take    (take),
      .full    (stage_full),
      .sample  (stage_sample)
   );

   lsbj_slot_shift #(.SLOT_BITS(SLOT_BITS)) i_shift (
      .clk          (clk),
      .rst_n        (rst_n),
      .fmt          (fmt),
      .launch       (launch),
      .stage_full   (stage_full),
      .stage_sample (stage_sample),
      .take         (take),
      .sd           (sd),
      .ws           (ws),
      .underrun     (underrun)
   );

   assign tx_empty = ~stage_full;
endmodule

// File: rtl/lsbj_audio_tx_chk.sv
`timescale 1ns/1ps
module lsbj_audio_tx_chk #(
   parameter int unsigned SLOT_BITS = 32
) (
   input logic clk,
   input logic rst_n,
   input logic cfg_fmt,
   input logic cfg_cpol,
   input logic tx_empty,
   input logic underrun,
   input logic sck,
   input logic ws,
   input logic sd
);
   localparam int unsigned CW = $clog2(SLOT_BITS) + 1;

   logic          prev_sck_q;
   logic          prev_ws_q;
   logic          seen_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_now;
   logic          launch_now;
   logic          slot_edge;

   assign launch_now = (sck == cfg_cpol) && (prev_sck_q != cfg_cpol);
   assign slot_edge  = (ws != prev_ws_q);
   assign cnt_now    = slot_edge ? '0 : (launch_now ? cnt_q + 1'b1 : cnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_sck_q <= 1'b0;
         prev_ws_q  <= 1'b1;
         seen_q     <= 1'b0;
         cnt_q      <= '0;
      end else begin
         prev_sck_q <= sck;
         prev_ws_q  <= ws;
         if (slot_edge) seen_q <= 1'b1;
         cnt_q      <= cnt_now;
      end
   end

   assert_slot_length_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_edge && seen_q) |-> (cnt_q == CW'(SLOT_BITS - 1)));

   assert_pad16_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_fmt && cnt_now < CW'(SLOT_BITS - 16)) |-> (sd == 1'b0));

   assert_pad24_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_fmt && cnt_now < CW'(SLOT_BITS - 24)) |-> (sd == 1'b0));

   assert_sd_on_launch_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sd) |-> (sck == cfg_cpol && $past(sck) != cfg_cpol));

   assert_ws_on_launch_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ws) |-> (sck == cfg_cpol && $past(sck) != cfg_cpol));

   assert_underrun_at_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(underrun) |-> !$stable(ws));

   assert_empty_at_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_empty) |-> !$stable(ws));
endmodule

bind lsbj_audio_tx lsbj_audio_tx_chk #(.SLOT_BITS(SLOT_BITS)) i_chk (.*);

// File: tb/test_lsbj_audio_tx.sv
`timescale 1ns/1ps
module test_lsbj_audio_tx;
   localparam int unsigned DIV_HALF = 4;
   localparam int unsigned SLOT     = 32;
   localparam int K_FULL = 0, K_SKIP = 1, K_HALF1 = 2, K_HALF2 = 3, K_DOUBLE = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_fmt = 1'b0;
   logic        cfg_cpol = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic        tx_empty, underrun, sck, ws, sd;

   always #2.5 clk = ~clk;

   lsbj_audio_tx #(.DIV_HALF(DIV_HALF), .SLOT_BITS(SLOT)) i_lsbj_audio_tx (
      .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_cpol(cfg_cpol),
      .wr_en(wr_en), .wr_data(wr_data), .tx_empty(tx_empty),
      .underrun(underrun), .sck(sck), .ws(ws), .sd(sd));

   typedef struct {
      logic        side;
      logic [31:0] word;
      logic        urun;
      logic        part;
   } exp_t;

   exp_t exp_q[$];
   logic exp_side;
   int   n_chk = 0;
   int   n_err = 0;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] slot_word(input logic [23:0] d);
      return cfg_fmt ? {8'h00, d} : {16'h0000, d[15:0]};
   endfunction

   task automatic push(input logic [31:0] w, input logic u, input logic p);
      exp_t e;
      e.side = exp_side; e.word = w; e.urun = u; e.part = p;
      exp_q.push_back(e);
      exp_side = ~exp_side;
   endtask

   task automatic wr(input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // Driver: one stimulus per slot, expectation pushed to the scoreboard
   task automatic feed(input int kind, input logic [23:0] d);
      case (kind)
         K_FULL: begin
            if (cfg_fmt) begin wr({8'hA5, d[23:16]}); wr(d[15:0]); end
            else wr(d[15:0]);
            push(slot_word(d), 1'b0, 1'b0);
         end
         K_SKIP: push(32'h0, 1'b1, 1'b0);
         K_HALF1: begin
            wr({8'h3C, d[23:16]});
            push(32'h0, 1'b1, 1'b1);
         end
         K_HALF2: begin
            wr(d[15:0]);
            push(slot_word(d), 1'b0, 1'b1);
         end
         default: begin
            if (cfg_fmt) begin wr({8'h5A, d[23:16]}); wr(d[15:0]); end
            else wr(d[15:0]);
            chk("R6", "tx_empty after full write", {31'h0, tx_empty}, 32'h0);
            wr(16'hFFFF);
            chk("R6", "tx_empty after ignored write", {31'h0, tx_empty}, 32'h0);
            push(slot_word(d), 1'b0, 1'b0);
         end
      endcase
   endtask

   task automatic wait_slot();
      logic w0;
      w0 = ws;
      @(negedge clk);
      while (ws == w0) @(negedge clk);
      chk("R10", "tx_empty at slot start", {31'h0, tx_empty}, 32'h1);
   endtask

   task automatic start_phase(input logic fmt, input logic cpol);
      rst_n = 1'b0;
      cfg_fmt = fmt; cfg_cpol = cpol;
      exp_q.delete();
      exp_side = 1'b0;
      repeat (3) @(negedge clk);
      chk("R9", "sck in reset", {31'h0, sck}, {31'h0, cpol});
      chk("R9", "ws in reset", {31'h0, ws}, 32'h1);
      chk("R9", "sd in reset", {31'h0, sd}, 32'h0);
      chk("R9", "tx_empty in reset", {31'h0, tx_empty}, 32'h1);
      chk("R9", "underrun in reset", {31'h0, underrun}, 32'h0);
      rst_n = 1'b1;
   endtask

   task automatic drain();
      for (int i = 0; i < 6 && exp_q.size() != 0; i++) wait_slot();
      chk("R1", "slots left unseen", exp_q.size(), 32'h0);
   endtask

   // Monitor: samples on the sck edge leaving idle, as a receiver would
   logic        m_prev_sck, m_ws, m_act, m_urun, m_prev_sd, m_prev_ws;
   logic [31:0] m_acc;
   int          m_cnt, m_cyc, m_last;

   always @(negedge clk) begin
      if (!rst_n) begin
         m_prev_sck = cfg_cpol; m_ws = 1'b1; m_act = 1'b0; m_cnt = 0;
         m_acc = '0; m_urun = 1'b0; m_cyc = 0; m_last = -1;
         m_prev_sd = 1'b0; m_prev_ws = 1'b1;
      end else begin
         m_cyc++;
         if (sd !== m_prev_sd || ws !== m_prev_ws)
            chk("R5", "sck now/before at data change", {30'h0, sck, m_prev_sck},
                {30'h0, cfg_cpol, ~cfg_cpol});
         if (sck != cfg_cpol && m_prev_sck == cfg_cpol) begin
            if (ws != m_ws) begin
               if (m_act) chk("R1", "bits in slot", m_cnt, SLOT);
               if (m_last >= 0) chk("R4", "bit period", m_cyc - m_last, 2 * DIV_HALF);
               m_ws = ws; m_act = 1'b1; m_cnt = 0; m_acc = '0; m_urun = underrun;
            end
            if (m_act && m_cnt < SLOT) begin
               m_acc = {m_acc[30:0], sd};
               m_cnt++;
               if (m_cnt == SLOT && exp_q.size() > 0) begin
                  exp_t e;
                  e = exp_q.pop_front();
                  chk("R1", "slot side", {31'h0, m_ws}, {31'h0, e.side});
                  chk(cfg_fmt ? "R3" : "R2", "slot word", m_acc, e.word);
                  chk(e.part ? "R8" : "R7", "underrun flag", {31'h0, m_urun}, {31'h0, e.urun});
               end
            end
            m_last = m_cyc;
         end
         m_prev_sck = sck; m_prev_sd = sd; m_prev_ws = ws;
      end
   end

   initial begin
      fork
         begin
            // 16-bit samples, idle-low clock
            start_phase(1'b0, 1'b0);
            feed(K_FULL, 24'h008001);
            wait_slot(); feed(K_DOUBLE, 24'h007FFE);
            wait_slot(); feed(K_FULL, 24'h00FFFF);
            wait_slot(); feed(K_SKIP, 24'h0);
            wait_slot(); feed(K_FULL, 24'h0000A5);
            wait_slot(); feed(K_FULL, 24'h005A5A);
            drain();
            // 24-bit samples, idle-high clock
            start_phase(1'b1, 1'b1);
            feed(K_FULL, 24'h800001);
            wait_slot(); feed(K_FULL, 24'h7FFFFF);
            wait_slot(); feed(K_HALF1, 24'hC3A55A);
            wait_slot(); feed(K_HALF2, 24'hC3A55A);
            wait_slot(); feed(K_DOUBLE, 24'h0F0F0F);
            wait_slot(); feed(K_SKIP, 24'h0);
            wait_slot(); feed(K_FULL, 24'hFFFFFF);
            drain();
         end
         begin
            repeat (150000) @(posedge clk);
            n_chk++; n_err++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule